// File: doc/BRIEF.md
# Circular Interrupt Event Queue Writer

This block posts per-channel event records into a small circular queue held in on-chip storage and lets a host walk the same queue to service them. Each 32-bit record carries a valid flag, a wrap flag, a byte of event flags and a 16-bit channel index. The producer pointer starts at the queue base. After it writes the record whose wrap flag is set, it jumps back to the base. Which record is last is therefore held in the queue contents, and no depth counter decides it.

Ownership passes through the valid flag held in the record. The producer writes only into a record whose valid flag is clear. If the record under its pointer is still valid, the producer holds the event off and reports the queue as full. The host sees the record under its own service pointer. A pop clears the valid flag and the event flags and moves the service pointer on, with the same return to base after the wrap record. A peek port reads any record by its offset in the queue.

Top module: `irq_evq_writer`

## Requirements
- R1: After reset, every record reads zero except the last one (offset Q_LEN-1), which reads 0x0000_0002 (wrap set only). Both pointers sit at Q_BASE, `ev_ready_o` is 1, and `q_full_o` and `svc_avail_o` are 0.
- R2: Record layout: bit 0 is the valid flag, bit 1 is the wrap flag, bits 7:2 are zero, bits 15:8 hold the event flags and bits 31:16 hold the channel index. An accepted event writes valid=1, its flags and its channel, and leaves the wrap bit unchanged.
- R3: When `ev_valid_i` is 1 and the record at the producer pointer has valid=0, the event is written at the next clock edge and `prod_addr_o` advances by one.
- R4: After a write to a record whose wrap bit is 1, `prod_addr_o` returns to Q_BASE.
- R5: While the record at the producer pointer has valid=1, `ev_ready_o` is 0 and `q_full_o` is 1. A presented event is then not written, the record is unchanged and `prod_addr_o` holds.
- R6: `svc_entry_o` shows the record at `svc_addr_o`, and `svc_avail_o` is its valid bit. A pop (`svc_pop_i`=1) of a valid record clears its valid and event bits, keeps its wrap bit and channel, and advances `svc_addr_o`. After the wrap record, `svc_addr_o` returns to Q_BASE.
- R7: A pop while the record at the service pointer has valid=0 is ignored: the record and `svc_addr_o` are unchanged.
- R8: A producer write and a host pop in the same cycle both take effect.
- R9: `peek_data_o` combinationally returns the record at offset `peek_idx_i` from the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, initialises the queue |
| ev_valid_i | input | 1 | Event presented |
| ev_flags_i | input | 8 | Event flags to post |
| ev_chan_i | input | 16 | Channel index to post |
| ev_ready_o | output | 1 | Record at producer pointer is free |
| q_full_o | output | 1 | Record at producer pointer is still owned by host |
| prod_addr_o | output | ADDR_W | Producer pointer, word address |
| svc_pop_i | input | 1 | Host pops the record at the service pointer |
| svc_avail_o | output | 1 | Record at service pointer is valid |
| svc_entry_o | output | 32 | Record at service pointer |
| svc_addr_o | output | ADDR_W | Service pointer, word address |
| peek_idx_i | input | OFF_W | Record offset to peek |
| peek_data_o | output | 32 | Peeked record |

## Verification
A corrupted record or pointer shows at the ports in the next cycle after the edge that caused it. A lost or duplicated wrap bit sends a pointer past the last record or back to base too early, and `prod_addr_o` or `svc_addr_o` is wrong right away. A valid bit left set, or cleared early, turns `ev_ready_o`, `q_full_o` and `svc_avail_o` wrong as soon as a pointer reaches that record. The peek port lets each record's contents be compared one cycle after every write and pop.

// File: rtl/irq_evq_pkg.sv
package irq_evq_pkg;
  localparam int unsigned ENT_W = 32;
  localparam int unsigned EV_W  = 8;
  localparam int unsigned CH_W  = 16;

  // bit 0 valid, bit 1 wrap, 15:8 events, 31:16 channel
  typedef struct packed {
    logic [CH_W-1:0] chan;
    logic [EV_W-1:0] ev;
    logic [5:0]      rsvd;
    logic            wrap;
    logic            vld;
  } evq_ent_t;
endpackage

// File: rtl/irq_evq_store.sv
module irq_evq_store
  import irq_evq_pkg::*;
#(
  parameter int unsigned Q_LEN = 8,
  localparam int unsigned OFF_W = $clog2(Q_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [OFF_W-1:0] wr_off_i,
  input  logic [EV_W-1:0]  wr_ev_i,
  input  logic [CH_W-1:0]  wr_ch_i,
  input  logic             clr_en_i,
  input  logic [OFF_W-1:0] clr_off_i,
  output evq_ent_t         ent_o [Q_LEN]
);
  evq_ent_t ent_q [Q_LEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < Q_LEN; i++) begin
        ent_q[i]      <= '0;
        ent_q[i].wrap <= (i == Q_LEN - 1);
      end
    end else begin
      for (int i = 0; i < Q_LEN; i++) begin
        if (wr_en_i && wr_off_i == OFF_W'(i)) begin
          // wrap bit is left as initialised
          ent_q[i].vld  <= 1'b1;
          ent_q[i].ev   <= wr_ev_i;
          ent_q[i].chan <= wr_ch_i;
        end else if (clr_en_i && clr_off_i == OFF_W'(i)) begin
          ent_q[i].vld <= 1'b0;
          ent_q[i].ev  <= '0;
        end
      end
    end
  end

  assign ent_o = ent_q;
endmodule

// File: rtl/irq_evq_ptr.sv
module irq_evq_ptr #(
  parameter int unsigned Q_LEN = 8,
  localparam int unsigned OFF_W = $clog2(Q_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             wrap_i,
  output logic [OFF_W-1:0] off_o
);
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= '0;
    else if (step_i) off_q <= wrap_i ? '0 : off_q + 1'b1;
  end

  assign off_o = off_q;
endmodule

// File: rtl/irq_evq_writer.sv
module irq_evq_writer
  import irq_evq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned Q_BASE = 32,
  parameter int unsigned Q_LEN  = 8,
  localparam int unsigned OFF_W = $clog2(Q_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic [7:0]        ev_flags_i,
  input  logic [15:0]       ev_chan_i,
  output logic              ev_ready_o,
  output logic              q_full_o,
  output logic [ADDR_W-1:0] prod_addr_o,
  input  logic              svc_pop_i,
  output logic              svc_avail_o,
  output logic [31:0]       svc_entry_o,
  output logic [ADDR_W-1:0] svc_addr_o,
  input  logic [OFF_W-1:0]  peek_idx_i,
  output logic [31:0]       peek_data_o
);
  evq_ent_t         ent [Q_LEN];
  logic [Q_LEN-1:0] vld_vec, wrap_vec;
  logic [OFF_W-1:0] prod_off, svc_off;
  logic             accept, pop;

  for (genvar g = 0; g < Q_LEN; g++) begin : g_flags
    assign vld_vec[g]  = ent[g].vld;
    assign wrap_vec[g] = ent[g].wrap;
  end

  assign ev_ready_o = ~vld_vec[prod_off];
  assign q_full_o   = vld_vec[prod_off];
  assign accept     = ev_valid_i & ~vld_vec[prod_off];
  assign pop        = svc_pop_i & vld_vec[svc_off];

  irq_evq_store #(.Q_LEN(Q_LEN)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (accept),
    .wr_off_i  (prod_off),
    .wr_ev_i   (ev_flags_i),
    .wr_ch_i   (ev_chan_i),
    .clr_en_i  (pop),
    .clr_off_i (svc_off),
    .ent_o     (ent)
  );

  irq_evq_ptr #(.Q_LEN(Q_LEN)) i_prod_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (accept),
    .wrap_i (wrap_vec[prod_off]),
    .off_o  (prod_off)
  );

  irq_evq_ptr #(.Q_LEN(Q_LEN)) i_svc_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (pop),
    .wrap_i (wrap_vec[svc_off]),
    .off_o  (svc_off)
  );

  assign prod_addr_o = ADDR_W'(Q_BASE) + ADDR_W'(prod_off);
  assign svc_addr_o  = ADDR_W'(Q_BASE) + ADDR_W'(svc_off);
  assign svc_avail_o = vld_vec[svc_off];
  assign svc_entry_o = ent[svc_off];

  always_comb begin
    peek_data_o = '0;
    if (int'(peek_idx_i) < int'(Q_LEN)) peek_data_o = ent[peek_idx_i];
  end
endmodule

// File: rtl/irq_evq_writer_chk.sv
module irq_evq_writer_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned Q_BASE = 32,
  parameter int unsigned Q_LEN  = 8,
  localparam int unsigned OFF_W = $clog2(Q_LEN)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ev_valid_i,
  input logic              ev_ready_o,
  input logic              q_full_o,
  input logic [ADDR_W-1:0] prod_addr_o,
  input logic              svc_pop_i,
  input logic              svc_avail_o,
  input logic [ADDR_W-1:0] svc_addr_o,
  input logic [Q_LEN-1:0]  vld_vec,
  input logic [Q_LEN-1:0]  wrap_vec
);
  logic [ADDR_W-1:0] p_rel, s_rel;
  logic [OFF_W-1:0]  poff, soff;
  logic              acc;

  assign p_rel = prod_addr_o - ADDR_W'(Q_BASE);
  assign s_rel = svc_addr_o - ADDR_W'(Q_BASE);
  assign poff  = p_rel[OFF_W-1:0];
  assign soff  = s_rel[OFF_W-1:0];
  assign acc   = ev_valid_i & ev_ready_o;

  // R1
  wrap_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wrap_vec) == 1 && wrap_vec[Q_LEN-1]);

  // R3
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(p_rel) < int'(Q_LEN) && int'(s_rel) < int'(Q_LEN));

  // R3
  prod_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !wrap_vec[poff] |=> prod_addr_o == $past(prod_addr_o) + 1'b1);

  // R3
  prod_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> vld_vec[$past(poff)]);

  // R4
  prod_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && wrap_vec[poff] |=> prod_addr_o == ADDR_W'(Q_BASE));

  // R5
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_i && q_full_o |=> $stable(prod_addr_o));

  // R6
  pop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_pop_i && svc_avail_o |=> !vld_vec[$past(soff)]);

  // R7
  pop_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_pop_i && !svc_avail_o && !acc |=> $stable(svc_addr_o) && $stable(vld_vec));
endmodule

bind irq_evq_writer irq_evq_writer_chk #(
  .ADDR_W (ADDR_W),
  .Q_BASE (Q_BASE),
  .Q_LEN  (Q_LEN)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ev_valid_i  (ev_valid_i),
  .ev_ready_o  (ev_ready_o),
  .q_full_o    (q_full_o),
  .prod_addr_o (prod_addr_o),
  .svc_pop_i   (svc_pop_i),
  .svc_avail_o (svc_avail_o),
  .svc_addr_o  (svc_addr_o),
  .vld_vec     (vld_vec),
  .wrap_vec    (wrap_vec)
);

// File: tb/test_irq_evq_writer.sv
`timescale 1ns/1ps
module test_irq_evq_writer;
  localparam int unsigned AW = 8;
  localparam int unsigned QB = 16;
  localparam int unsigned QL = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ev_valid_i = 1'b0;
  logic [7:0]    ev_flags_i = '0;
  logic [15:0]   ev_chan_i = '0;
  logic          ev_ready_o, q_full_o, svc_avail_o;
  logic [AW-1:0] prod_addr_o, svc_addr_o;
  logic          svc_pop_i = 1'b0;
  logic [31:0]   svc_entry_o, peek_data_o;
  logic [1:0]    peek_idx_i = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  irq_evq_writer #(.ADDR_W(AW), .Q_BASE(QB), .Q_LEN(QL)) i_irq_evq_writer (.*);

  typedef struct packed {
    logic        pop;
    logic [7:0]  ev;
    logic [15:0] ch;
    logic        ok;
    logic [31:0] word;
    logic [7:0]  paddr;
    logic [7:0]  saddr;
  } vec_t;

  // word: record expected at the touched slot (push: after write; pop: before pop)
  localparam vec_t VEC [12] = '{
    '{1'b0, 8'h01, 16'h0100, 1'b1, 32'h0100_0101, 8'd17, 8'd16},
    '{1'b0, 8'h02, 16'h0101, 1'b1, 32'h0101_0201, 8'd18, 8'd16},
    '{1'b0, 8'h04, 16'h0102, 1'b1, 32'h0102_0401, 8'd19, 8'd16},
    '{1'b0, 8'h08, 16'h0103, 1'b1, 32'h0103_0803, 8'd16, 8'd16},
    '{1'b0, 8'h10, 16'h0104, 1'b0, 32'h0100_0101, 8'd16, 8'd16},
    '{1'b1, 8'h00, 16'h0000, 1'b1, 32'h0100_0101, 8'd16, 8'd17},
    '{1'b0, 8'h20, 16'h0105, 1'b1, 32'h0105_2001, 8'd17, 8'd17},
    '{1'b1, 8'h00, 16'h0000, 1'b1, 32'h0101_0201, 8'd17, 8'd18},
    '{1'b1, 8'h00, 16'h0000, 1'b1, 32'h0102_0401, 8'd17, 8'd19},
    '{1'b1, 8'h00, 16'h0000, 1'b1, 32'h0103_0803, 8'd17, 8'd16},
    '{1'b1, 8'h00, 16'h0000, 1'b1, 32'h0105_2001, 8'd17, 8'd17},
    '{1'b1, 8'h00, 16'h0000, 1'b0, 32'h0101_0000, 8'd17, 8'd17}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic peek(input int off, output logic [31:0] d);
    peek_idx_i = 2'(off);
    #1 d = peek_data_o;
  endtask

  task automatic reset_check();
    logic [31:0] d;
    rst_ni = 1'b0;
    ev_valid_i = 1'b0;
    svc_pop_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < QL; i++) begin
      peek(i, d);
      chk("R1 R9 init record", d, (i == QL - 1) ? 32'h2 : 32'h0);
    end
    chk("R1 prod_addr", 32'(prod_addr_o), QB);
    chk("R1 svc_addr", 32'(svc_addr_o), QB);
    chk("R1 flags", {29'b0, ev_ready_o, q_full_o, svc_avail_o}, 32'b100);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  slot;
    string       req;
    reset_check();

    for (int r = 0; r < 12; r++) begin
      @(negedge clk_i);
      if (VEC[r].pop) begin
        req = VEC[r].ok ? "R6" : "R7";
        svc_pop_i = 1'b1;
        slot = svc_addr_o;
        #1;
        chk({req, " avail"}, 32'(svc_avail_o), 32'(VEC[r].ok));
        chk({req, " entry"}, svc_entry_o, VEC[r].word);
      end else begin
        req = !VEC[r].ok ? "R5" : (VEC[r].paddr == 8'(QB) ? "R4" : "R3");
        ev_valid_i = 1'b1;
        ev_flags_i = VEC[r].ev;
        ev_chan_i  = VEC[r].ch;
        slot = prod_addr_o;
        #1;
        chk({req, " ready"}, 32'(ev_ready_o), 32'(VEC[r].ok));
        chk({req, " full"}, 32'(q_full_o), 32'(!VEC[r].ok));
      end
      @(negedge clk_i);
      ev_valid_i = 1'b0;
      svc_pop_i = 1'b0;
      chk({req, " prod_addr"}, 32'(prod_addr_o), 32'(VEC[r].paddr));
      chk({req, " svc_addr"}, 32'(svc_addr_o), 32'(VEC[r].saddr));
      peek(int'(slot) - QB, d);
      if (VEC[r].pop)
        chk({req, " slot after pop"}, d,
            VEC[r].ok ? {VEC[r].word[31:16], 8'h00, VEC[r].word[7:1], 1'b0} : VEC[r].word);
      else
        chk({req, " R2 layout"}, d, VEC[r].word);
    end

    // R8: push then simultaneous push and pop
    @(negedge clk_i);
    ev_valid_i = 1'b1; ev_flags_i = 8'h40; ev_chan_i = 16'h0200;
    @(negedge clk_i);
    ev_flags_i = 8'h80; ev_chan_i = 16'h0201;
    svc_pop_i = 1'b1;
    #1 chk("R8 avail", 32'(svc_avail_o), 32'd1);
    chk("R8 ready", 32'(ev_ready_o), 32'd1);
    @(negedge clk_i);
    ev_valid_i = 1'b0; svc_pop_i = 1'b0;
    chk("R8 prod_addr", 32'(prod_addr_o), 32'd19);
    chk("R8 svc_addr", 32'(svc_addr_o), 32'd18);
    peek(1, d);
    chk("R8 popped record", d, 32'h0200_0000);
    peek(2, d);
    chk("R8 written record", d, 32'h0201_8001);

    // R1: reset mid-run restores the initial image
    reset_check();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule